// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block turns a bank of wired interrupt inputs into message-signalled write requests. Each input line has its own two-word redirection entry. The entry holds a mask, a polarity select, a trigger-mode select, an 8-bit message data value and an 8-bit destination ID/EID pair. Software reaches the entries indirectly. It writes an internal index to a select register, then reads or writes the chosen word through a data window. A read-only version word reports the version number and how many entries exist.

Every input passes through a two-flop synchroniser, and its polarity is applied before detection. Each line then runs a small state machine with the states `LN_IDLE`, `LN_PEND` and `LN_INSVC`:
- **Edge mode.** An inactive-to-active transition moves a line from `LN_IDLE` to `LN_PEND`.
- **Level mode.** An active, unmasked input moves the line from `LN_IDLE` to `LN_PEND`.
- **On a grant.** `LN_PEND` returns to `LN_IDLE` in edge mode, or moves to `LN_INSVC` in level mode.
- **On a matching end-of-interrupt write.** `LN_INSVC` returns to `LN_IDLE`. If the input is still active and unmasked, the line re-enters `LN_PEND` on the next cycle.

The message master has two states, `MS_IDLE` and `MS_BUSY`. In `MS_IDLE` it grants the lowest-index line that is pending and unmasked, latches that line's address and data, and moves to `MS_BUSY`. It stays in `MS_BUSY`, holding the request, until the request is accepted.

Top module: `irq_msg_router`

## Requirements
- R1: Bus byte offsets: 0x00 is the select register, 0x10 is the data window and 0x40 is the end-of-interrupt (EOI) register. A window access reaches the internal index last written to select, and reading select returns that index.
- R2: Internal index 0x01 is read-only. It reads as bits 7:0 = VERSION (default 0x21) and bits 23:16 = N_LINES-1; all other bits read 0. A window write to this index changes nothing.
- R3: The entry for line n has its low word at index 0x10+2n and its high word at index 0x11+2n.
  - Low word: bit 16 = mask, bit 15 = level trigger, bit 13 = active-low, bit 8 = a stored priority hint with no effect, bits 7:0 = message data.
  - High word: bits 31:24 = destination ID, bits 23:16 = destination EID.
  - All other bits read 0. A window read issued right after a write returns the value just written.
- R4: After reset every low word reads 0x00010000 (masked), every high word reads 0, and no request is presented.
- R5: A message has address {4'hF, EID, ID, 12'h000} and data {24'h0, message data}.
- R6: In edge mode, one message is sent per inactive-to-active transition. An input that stays active sends nothing more.
- R7: When the active-low bit is set, a falling input is the active transition.
- R8: In level mode, a line sends one message and then sends nothing more until an EOI.
- R9: Writing value v to the EOI register re-arms every level line whose data equals v. A re-armed line that is still active and unmasked sends a new message. An EOI with a different value has no effect.
- R10: A masked line is never granted. A masked level line sends nothing. An edge seen while the line is masked is kept and is delivered once the line is unmasked.
- R11: When several lines are pending, messages go out lowest index first.
- R12: A presented request keeps msg_valid_o, msg_addr_o and msg_data_o stable until msg_ready_i accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_LINES | Asynchronous interrupt lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; data appears one cycle later |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Message request accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The hardest cases to reach from the ports are two:
- several lines sitting pending at the same moment, which is needed to see the arbitration order;
- a level line that is still asserted when its EOI arrives.

For the first, the bench holds msg_ready_i low while it raises three lines together, so the requests queue up behind the first one. It then checks that the held request does not move and releases ready.

For the second, the bench keeps the level input high across a mismatched EOI and then a matching EOI. Only the matching one should produce a message.

An active-low line is first parked in masked level mode, so that changing its polarity cannot create a false edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_PEND  = 2'd1,
        LN_INSVC = 2'd2
    } line_state_e;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_BUSY = 1'b1
    } msg_state_e;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic       lowpri;
        logic [7:0] data;
    } lo_entry_t;

    typedef struct packed {
        logic [7:0] dest_id;
        logic [7:0] dest_eid;
    } hi_entry_t;

    localparam int LO_MASK_BIT   = 16;
    localparam int LO_LEVEL_BIT  = 15;
    localparam int LO_ACTLOW_BIT = 13;
    localparam int LO_LOWPRI_BIT = 8;

    localparam lo_entry_t LO_RESET = '{mask: 1'b1, level: 1'b0, act_low: 1'b0,
                                       lowpri: 1'b0, data: 8'h00};

    function automatic logic [31:0] pack_lo(input lo_entry_t e);
        logic [31:0] w;
        w                = '0;
        w[LO_MASK_BIT]   = e.mask;
        w[LO_LEVEL_BIT]  = e.level;
        w[LO_ACTLOW_BIT] = e.act_low;
        w[LO_LOWPRI_BIT] = e.lowpri;
        w[7:0]           = e.data;
        return w;
    endfunction

    function automatic lo_entry_t unpack_lo(input logic [31:0] w);
        lo_entry_t e;
        e.mask    = w[LO_MASK_BIT];
        e.level   = w[LO_LEVEL_BIT];
        e.act_low = w[LO_ACTLOW_BIT];
        e.lowpri  = w[LO_LOWPRI_BIT];
        e.data    = w[7:0];
        return e;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic level_i,
    input  logic mask_i,
    input  logic grant_i,
    input  logic eoi_hit_i,
    output logic req_o
);

    line_state_e state_q, state_d;
    logic        act_prev_q;
    logic        rise;

    // Edge detection on the polarity-corrected input, tracked in every mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_prev_q <= 1'b0;
        else        act_prev_q <= act_i;
    end

    assign rise = act_i & ~act_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (level_i) begin
                    if (act_i && !mask_i) state_d = LN_PEND;
                end else if (rise) begin
                    state_d = LN_PEND;
                end
            end
            LN_PEND: begin
                if (grant_i) state_d = level_i ? LN_INSVC : LN_IDLE;
            end
            LN_INSVC: begin
                if (eoi_hit_i) state_d = LN_IDLE;
            end
            default: state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        req_o = (state_q == LN_PEND) && !mask_i;
    end

endmodule

// File: rtl/irq_msg_master.sv
module irq_msg_master
    import irq_router_pkg::*;
#(
    parameter int         N_LINES  = 16,
    parameter logic [3:0] ADDR_TOP = 4'hF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_LINES-1:0]      req_i,
    input  logic [N_LINES-1:0][7:0] data_i,
    input  logic [N_LINES-1:0][7:0] id_i,
    input  logic [N_LINES-1:0][7:0] eid_i,
    output logic [N_LINES-1:0]      grant_o,
    output logic                    m_valid_o,
    input  logic                    m_ready_i,
    output logic [31:0]             m_addr_o,
    output logic [31:0]             m_data_o
);

    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    msg_state_e       state_q, state_d;
    logic [IDX_W-1:0] pick;
    logic             found;
    logic             take;

    // Lowest index wins: scan downward so the last hit is the smallest index
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign take = (state_q == MS_IDLE) && found;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (found)     state_d = MS_BUSY;
            MS_BUSY: if (m_ready_i) state_d = MS_IDLE;
            default:                state_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr_o <= '0;
            m_data_o <= '0;
        end else if (take) begin
            m_addr_o <= {ADDR_TOP, eid_i[pick], id_i[pick], 12'h000};
            m_data_o <= {24'h0, data_i[pick]};
        end
    end

    always_comb begin
        grant_o = '0;
        if (take) grant_o[pick] = 1'b1;
        m_valid_o = (state_q == MS_BUSY);
    end

endmodule

// File: rtl/irq_msg_router.sv
module irq_msg_router
    import irq_router_pkg::*;
#(
    parameter int         N_LINES      = 16,
    parameter logic [7:0] VERSION      = 8'h21,
    parameter int         ADDR_W       = 8,
    parameter logic [3:0] MSG_ADDR_TOP = 4'hF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               msg_valid_o,
    input  logic               msg_ready_i,
    output logic [31:0]        msg_addr_o,
    output logic [31:0]        msg_data_o
);

    localparam int              LINE_W     = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam logic [7:0]      IDX_VER    = 8'h01;
    localparam logic [7:0]      IDX_ENTRY0 = 8'h10;
    localparam int              IDX_LAST   = 16 + 2 * N_LINES - 1;
    localparam logic [ADDR_W-1:0] OFS_SEL  = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_WIN  = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] OFS_EOI  = ADDR_W'(8'h40);

    logic [7:0]                sel_q;
    logic                      wr_sel, wr_win, wr_eoi;
    logic                      entry_hit, ent_hi;
    logic [LINE_W-1:0]         ent_line;
    logic [31:0]               win_rd;

    logic [N_LINES-1:0]        irq_sync_v;
    logic [N_LINES-1:0]        line_req, line_grant, line_mask;
    logic [N_LINES-1:0][7:0]   data_vec, id_vec, eid_vec;
    lo_entry_t [N_LINES-1:0]   lo_vec;
    hi_entry_t [N_LINES-1:0]   hi_vec;

    assign wr_sel = bus_wr_i && (bus_addr_i == OFS_SEL);
    assign wr_win = bus_wr_i && (bus_addr_i == OFS_WIN);
    assign wr_eoi = bus_wr_i && (bus_addr_i == OFS_EOI);

    assign entry_hit = (sel_q >= IDX_ENTRY0) && (int'(sel_q) <= IDX_LAST);
    assign ent_hi    = sel_q[0];
    assign ent_line  = LINE_W'((sel_q - IDX_ENTRY0) >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= bus_wdata_i[7:0];
    end

    irq_sync #(.WIDTH(N_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_i),
        .sync_o  (irq_sync_v)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        lo_entry_t lo_q;
        hi_entry_t hi_q;
        logic      act;
        logic      eoi_hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= LO_RESET;
                hi_q <= '0;
            end else if (wr_win && entry_hit && (ent_line == LINE_W'(g))) begin
                if (ent_hi) hi_q <= hi_entry_t'(bus_wdata_i[31:16]);
                else        lo_q <= unpack_lo(bus_wdata_i);
            end
        end

        assign act     = irq_sync_v[g] ^ lo_q.act_low;
        assign eoi_hit = wr_eoi && lo_q.level && (lo_q.data == bus_wdata_i[7:0]);

        irq_line_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act),
            .level_i   (lo_q.level),
            .mask_i    (lo_q.mask),
            .grant_i   (line_grant[g]),
            .eoi_hit_i (eoi_hit),
            .req_o     (line_req[g])
        );

        assign lo_vec[g]    = lo_q;
        assign hi_vec[g]    = hi_q;
        assign data_vec[g]  = lo_q.data;
        assign id_vec[g]    = hi_q.dest_id;
        assign eid_vec[g]   = hi_q.dest_eid;
        assign line_mask[g] = lo_q.mask;
    end

    always_comb begin
        win_rd = '0;
        if (sel_q == IDX_VER) begin
            win_rd = {8'h00, 8'(N_LINES - 1), 8'h00, VERSION};
        end else if (entry_hit) begin
            if (ent_hi) win_rd = {hi_vec[ent_line], 16'h0000};
            else        win_rd = pack_lo(lo_vec[ent_line]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
        end else if (bus_rd_i) begin
            case (bus_addr_i)
                OFS_SEL: bus_rdata_o <= {24'h0, sel_q};
                OFS_WIN: bus_rdata_o <= win_rd;
                default: bus_rdata_o <= '0;
            endcase
        end
    end

    irq_msg_master #(.N_LINES(N_LINES), .ADDR_TOP(MSG_ADDR_TOP)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (line_req),
        .data_i    (data_vec),
        .id_i      (id_vec),
        .eid_i     (eid_vec),
        .grant_o   (line_grant),
        .m_valid_o (msg_valid_o),
        .m_ready_i (msg_ready_i),
        .m_addr_o  (msg_addr_o),
        .m_data_o  (msg_data_o)
    );

endmodule

// File: rtl/irq_msg_router_chk.sv
module irq_msg_router_chk #(
    parameter int         N_LINES  = 16,
    parameter logic [3:0] ADDR_TOP = 4'hF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [31:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic [N_LINES-1:0] req_vec,
    input logic [N_LINES-1:0] grant_vec,
    input logic [N_LINES-1:0] mask_vec
);

    // R12
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R4
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !msg_valid);

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R11
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0) |-> ((req_vec & (grant_vec - N_LINES'(1))) == '0));

    // R10
    masked_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec & mask_vec) == '0);

    // R5
    msg_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[31:28] == ADDR_TOP && msg_addr[11:0] == 12'h000
                       && msg_data[31:8] == 24'h0));

endmodule

bind irq_msg_router irq_msg_router_chk #(.N_LINES(N_LINES), .ADDR_TOP(MSG_ADDR_TOP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid_o),
    .msg_ready (msg_ready_i),
    .msg_addr  (msg_addr_o),
    .msg_data  (msg_data_o),
    .req_vec   (line_req),
    .grant_vec (line_grant),
    .mask_vec  (line_mask)
);

// File: tb/irq_msg_router_tb.sv
module irq_msg_router_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid, msg_ready = 1'b1;
    logic [31:0] msg_addr, msg_data;

    always #2.5 clk = ~clk;

    irq_msg_router #(.N_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
        .msg_addr_o(msg_addr), .msg_data_o(msg_data)
    );

    int          checks = 0, errors = 0;
    string       phase = "R4";
    logic [63:0] exp_q[$];
    logic [63:0] mon_exp;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: the handshake completes at the next rising edge
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {phase, " unexpected message"}, {msg_addr, msg_data}, 64'h0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk({msg_addr, msg_data} == mon_exp, {phase, " message"}, {msg_addr, msg_data}, mon_exp);
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, d);
    endtask

    task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10, d);
    endtask

    task automatic program_line(input int n, input logic [31:0] lo, input logic [7:0] id, input logic [7:0] eid);
        win_write(8'(8'h11 + 2 * n), {id, eid, 16'h0});
        win_write(8'(8'h10 + 2 * n), lo);
    endtask

    task automatic expect_msg(input logic [7:0] id, input logic [7:0] eid, input logic [7:0] data);
        exp_q.push_back({4'hF, eid, id, 12'h000, 24'h0, data});
    endtask

    task automatic drained(input string tag);
        settle(25);
        chk(exp_q.size() == 0, {tag, " all expected messages delivered"}, 64'(exp_q.size()), 64'h0);
    endtask

    logic [31:0] rd;
    logic [31:0] held_addr;

    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(2);

        // Reset state
        phase = "R4";
        chk(msg_valid == 1'b0, "R4 no request after reset", 64'(msg_valid), 64'h0);
        win_read(8'h10, rd);
        chk(rd == 32'h0001_0000, "R4 line 0 low word reset", 64'(rd), 64'h0001_0000);
        win_read(8'h2F, rd);
        chk(rd == 32'h0, "R4 line 15 high word reset", 64'(rd), 64'h0);

        // Version word and its read-only nature
        phase = "R2";
        win_read(8'h01, rd);
        chk(rd == 32'h000F_0021, "R2 version word", 64'(rd), 64'h000F_0021);
        win_write(8'h01, 32'hFFFF_FFFF);
        win_read(8'h01, rd);
        chk(rd == 32'h000F_0021, "R2 version ignores writes", 64'(rd), 64'h000F_0021);

        // Select register
        phase = "R1";
        bus_write(8'h00, 32'h0000_002A);
        bus_read(8'h00, rd);
        chk(rd == 32'h0000_002A, "R1 select readback", 64'(rd), 64'h2A);

        // Window readback right after write, line 15 (kept masked)
        phase = "R3";
        win_write(8'h2E, 32'h0001_A135);
        bus_read(8'h10, rd);
        chk(rd == 32'h0001_A135, "R3 low word readback", 64'(rd), 64'h0001_A135);
        win_write(8'h2E, 32'hFFFF_FFFF);
        bus_read(8'h10, rd);
        chk(rd == 32'h0001_A1FF, "R3 reserved low bits read 0", 64'(rd), 64'h0001_A1FF);
        win_write(8'h2F, 32'h5A3C_FFFF);
        bus_read(8'h10, rd);
        chk(rd == 32'h5A3C_0000, "R3 high word readback", 64'(rd), 64'h5A3C_0000);

        // Edge line 0
        phase = "R6";
        program_line(0, 32'h0000_0041, 8'h12, 8'h34);
        expect_msg(8'h12, 8'h34, 8'h41);
        irq[0] = 1'b1;
        drained("R6");
        settle(20);
        chk(exp_q.size() == 0, "R6 steady active sends nothing more", 64'(exp_q.size()), 64'h0);
        irq[0] = 1'b0;
        settle(10);

        // Active-low edge line 1, parked first as masked level
        phase = "R7";
        win_write(8'h12, 32'h0001_A042);
        irq[1] = 1'b1;
        settle(6);
        program_line(1, 32'h0000_2042, 8'hAB, 8'hCD);
        settle(6);
        expect_msg(8'hAB, 8'hCD, 8'h42);
        irq[1] = 1'b0;
        drained("R7");

        // Level line 2 and EOI
        phase = "R8";
        program_line(2, 32'h0000_8055, 8'h01, 8'h02);
        expect_msg(8'h01, 8'h02, 8'h55);
        irq[2] = 1'b1;
        drained("R8");
        settle(20);
        chk(exp_q.size() == 0, "R8 level line silent while in service", 64'(exp_q.size()), 64'h0);
        phase = "R9";
        bus_write(8'h40, 32'h0000_0066);
        drained("R9 mismatched EOI");
        expect_msg(8'h01, 8'h02, 8'h55);
        bus_write(8'h40, 32'h0000_0055);
        drained("R9 matching EOI refires");
        irq[2] = 1'b0;
        settle(6);
        bus_write(8'h40, 32'h0000_0055);
        drained("R9 EOI on inactive line");

        // Masking
        phase = "R10";
        program_line(3, 32'h0001_8077, 8'h00, 8'h00);
        irq[3] = 1'b1;
        drained("R10 masked level line");
        irq[3] = 1'b0;
        program_line(4, 32'h0001_0078, 8'h00, 8'h00);
        irq[4] = 1'b1;
        settle(5);
        irq[4] = 1'b0;
        drained("R10 masked edge held");
        expect_msg(8'h00, 8'h00, 8'h78);
        win_write(8'h18, 32'h0000_0078);
        drained("R10 held edge after unmask");

        // Priority and hold
        phase = "R11";
        program_line(5, 32'h0000_0095, 8'h05, 8'h50);
        program_line(6, 32'h0000_0096, 8'h06, 8'h60);
        program_line(9, 32'h0000_0099, 8'h09, 8'h90);
        msg_ready = 1'b0;
        expect_msg(8'h05, 8'h50, 8'h95);
        expect_msg(8'h06, 8'h60, 8'h96);
        expect_msg(8'h09, 8'h90, 8'h99);
        irq[9] = 1'b1; irq[5] = 1'b1; irq[6] = 1'b1;
        settle(10);
        held_addr = msg_addr;
        chk(msg_valid == 1'b1, "R12 request presented while not ready", 64'(msg_valid), 64'h1);
        settle(5);
        chk(msg_valid == 1'b1 && msg_addr == held_addr, "R12 request held stable",
            64'(msg_addr), 64'(held_addr));
        chk(msg_addr == 32'hF500_5000, "R11 lowest line presented first", 64'(msg_addr), 64'hF500_5000);
        msg_ready = 1'b1;
        drained("R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule